// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept. The destination address arrives one byte per cycle at the start of the frame. While the bytes stream in, the filter does three things: it compares them with a programmed 48-bit station address, it tracks whether all of them are 0xFF, and it folds them into a CRC-32 whose top bits index a 64-bit multicast hash table. When the frame ends, the receive path supplies the frame length and the CRC and alignment error flags. The filter then applies a five-bit policy word and emits a one-cycle verdict. The verdict carries an accept bit and a match-group bit, which tells a physical-address hit apart from a multicast or broadcast hit.

A four-state machine sequences each frame. In `ST_IDLE` it waits for `frame_start`. In `ST_ADDR` it collects destination bytes. In `ST_HOLD` the address is complete and it waits for frame end. `ST_REPORT` presents the verdict for one cycle. The transitions are:
- `frame_start` moves any state to `ST_ADDR`, clearing the address trackers.
- `ST_ADDR` goes to `ST_HOLD` once six bytes are in, or to `ST_REPORT` if `frame_end` arrives first.
- `ST_HOLD` goes to `ST_REPORT` on `frame_end`.
- `ST_REPORT` goes back to `ST_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: With `rx_policy[4]` (promiscuous) clear, a destination whose first byte has bit 0 clear is accepted only if every byte k (k = 0 first on the wire) equals `station_addr[8k+7:8k]`.
- R2: With `rx_policy[4]` set, every destination whose first byte has bit 0 clear passes the address stage.
- R3: The all-ones destination passes the address stage only when `rx_policy[2]` (take broadcast) is set.
- R4: A destination that is not all ones and has bit 0 of its first byte set is multicast. It is rejected when `rx_policy[3]` is clear. Otherwise it passes only if `hash_table[idx]` is 1. The value idx is bits 31:26 of a CRC register computed as follows: start at 0xFFFFFFFF; feed the six bytes first to last, each least significant bit first; for each bit, shift left and XOR in 0x04C11DB7 when the old bit 31 differs from the data bit; apply no final inversion. Bits 5:3 of idx pick the table byte and bits 2:0 pick the bit within it.
- R5: A frame with `frame_len` below 64 is rejected unless `rx_policy[1]` (keep short) is set.
- R6: A frame with `crc_err` or `align_err` set is rejected unless `rx_policy[0]` (keep bad) is set.
- R7: `match_group` is 0 for an accepted physical destination and 1 for an accepted multicast or broadcast destination. It is 0 whenever `accept` is 0.
- R8: `dec_valid` is a single-cycle pulse in the cycle after `frame_end` is sampled. `accept` and `match_group` are 0 outside that pulse and during and after reset.
- R9: `frame_end` before six destination bytes yields a rejected verdict. `frame_end` with no open frame yields no verdict. A new `frame_start` discards any partial address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_policy | input | 5 | Policy: bit0 keep bad, bit1 keep short, bit2 take broadcast, bit3 take multicast, bit4 promiscuous |
| station_addr | input | 8*ADDR_BYTES | Station address, byte k in bits 8k+7:8k |
| hash_table | input | 2**HASH_BITS | Multicast hash table, bit n selected by hash index n |
| frame_start | input | 1 | Opens a frame and clears address state |
| dest_valid | input | 1 | Qualifies `dest_byte` |
| dest_byte | input | 8 | Destination address byte, first byte first |
| frame_end | input | 1 | Closes the frame; length and error flags are sampled |
| frame_len | input | LEN_W | Frame length in bytes |
| crc_err | input | 1 | Frame failed its CRC check |
| align_err | input | 1 | Frame did not end on a byte boundary |
| dec_valid | output | 1 | Verdict strobe |
| accept | output | 1 | Frame is kept |
| match_group | output | 1 | 0 physical hit, 1 multicast or broadcast hit |

## Verification
The properties assume that `frame_len`, `crc_err` and `align_err` are meaningful in the cycle `frame_end` is high. They also assume that `frame_start` and `frame_end` are not raised in the same cycle when a verdict is expected. The stimulus keeps to this: each frame is one start pulse, then destination bytes with random idle gaps, then one end pulse carrying length and error flags. Only a few directed cases deliberately close frames early, restart them midway or raise `frame_end` with no open frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_REPORT
    } rxf_state_e;

    typedef enum logic [1:0] {
        CLS_PHYS,
        CLS_MCAST,
        CLS_BCAST
    } addr_class_e;

    // Policy word bit positions
    localparam int POL_KEEP_BAD   = 0;
    localparam int POL_KEEP_SHORT = 1;
    localparam int POL_TAKE_BCAST = 2;
    localparam int POL_TAKE_MCAST = 3;
    localparam int POL_PROMISC    = 4;
    localparam int POL_W          = 5;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic promisc;
        logic take_mcast;
        logic take_bcast;
        logic keep_short;
        logic keep_bad;
    } rx_policy_t;

    function automatic rx_policy_t decode_policy(input logic [POL_W-1:0] raw);
        rx_policy_t p;
        p.promisc    = raw[POL_PROMISC];
        p.take_mcast = raw[POL_TAKE_MCAST];
        p.take_bcast = raw[POL_TAKE_BCAST];
        p.keep_short = raw[POL_KEEP_SHORT];
        p.keep_bad   = raw[POL_KEEP_BAD];
        return p;
    endfunction

    // One byte of the serial CRC, least significant data bit first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    input  logic [7:0]           data,
    output logic [HASH_BITS-1:0] idx
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= CRC_INIT;
        end else if (step) begin
            crc_q <= crc_byte(crc_q, data);
        end
    end

    assign idx = crc_q[31 -: HASH_BITS];

endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic [7:0]              data,
    input  logic [8*ADDR_BYTES-1:0] station,
    output logic                    done,
    output logic                    uni_eq,
    output logic                    all_ones,
    output logic                    group_bit
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

    logic [7:0]       sta_byte [ADDR_BYTES];
    logic [7:0]       sel_byte;
    logic [CNT_W-1:0] cnt_q;
    logic             eq_q, ones_q, grp_q;
    logic             take;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
        assign sta_byte[g] = station[8*g +: 8];
    end

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cnt_q == CNT_W'(i)) sel_byte = sta_byte[i];
        end
    end

    assign take = step && (cnt_q != LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            eq_q   <= 1'b1;
            ones_q <= 1'b1;
            grp_q  <= 1'b0;
        end else if (take) begin
            cnt_q  <= cnt_q + 1'b1;
            eq_q   <= eq_q & (data == sel_byte);
            ones_q <= ones_q & (data == 8'hFF);
            if (cnt_q == '0) grp_q <= data[0];
        end
    end

    assign done      = (cnt_q == LAST);
    assign uni_eq    = eq_q;
    assign all_ones  = ones_q;
    assign group_bit = grp_q;

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6,
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 64
) (
    input  rx_policy_t                pol,
    input  logic                      done,
    input  logic                      uni_eq,
    input  logic                      all_ones,
    input  logic                      group_bit,
    input  logic [(1<<HASH_BITS)-1:0] hash_table,
    input  logic [HASH_BITS-1:0]      idx,
    input  logic [LEN_W-1:0]          frame_len,
    input  logic                      crc_err,
    input  logic                      align_err,
    output logic                      ok,
    output logic                      grp
);

    addr_class_e cls;
    logic        addr_ok, len_ok, err_ok;

    always_comb begin
        if (all_ones)       cls = CLS_BCAST;
        else if (group_bit) cls = CLS_MCAST;
        else                cls = CLS_PHYS;
    end

    always_comb begin
        unique case (cls)
            CLS_BCAST: addr_ok = pol.take_bcast;
            CLS_MCAST: addr_ok = pol.take_mcast && hash_table[idx];
            CLS_PHYS:  addr_ok = pol.promisc || uni_eq;
            default:   addr_ok = 1'b0;
        endcase
    end

    assign len_ok = (frame_len >= LEN_W'(MIN_LEN)) || pol.keep_short;
    assign err_ok = !(crc_err || align_err) || pol.keep_bad;
    assign ok     = done && addr_ok && len_ok && err_ok;
    assign grp    = ok && (cls != CLS_PHYS);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [4:0]                rx_policy,
    input  logic [8*ADDR_BYTES-1:0]   station_addr,
    input  logic [(1<<HASH_BITS)-1:0] hash_table,
    input  logic                      frame_start,
    input  logic                      dest_valid,
    input  logic [7:0]                dest_byte,
    input  logic                      frame_end,
    input  logic [LEN_W-1:0]          frame_len,
    input  logic                      crc_err,
    input  logic                      align_err,
    output logic                      dec_valid,
    output logic                      accept,
    output logic                      match_group
);

    rxf_state_e           state_q, state_d;
    rx_policy_t           pol;
    logic                 trk_step, capture;
    logic                 addr_done, uni_eq, all_ones, group_bit;
    logic [HASH_BITS-1:0] idx;
    logic                 v_ok, v_grp;
    logic                 dec_q, acc_q, grp_q;

    assign pol      = decode_policy(rx_policy);
    assign trk_step = dest_valid && (state_q == ST_ADDR) && !frame_start;
    assign capture  = frame_end && !frame_start &&
                      ((state_q == ST_ADDR) || (state_q == ST_HOLD));

    rxf_addr_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start),
        .step     (trk_step),
        .data     (dest_byte),
        .station  (station_addr),
        .done     (addr_done),
        .uni_eq   (uni_eq),
        .all_ones (all_ones),
        .group_bit(group_bit)
    );

    rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(frame_start),
        .step (trk_step && !addr_done),
        .data (dest_byte),
        .idx  (idx)
    );

    rxf_verdict #(.HASH_BITS(HASH_BITS), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_verdict (
        .pol       (pol),
        .done      (addr_done),
        .uni_eq    (uni_eq),
        .all_ones  (all_ones),
        .group_bit (group_bit),
        .hash_table(hash_table),
        .idx       (idx),
        .frame_len (frame_len),
        .crc_err   (crc_err),
        .align_err (align_err),
        .ok        (v_ok),
        .grp       (v_grp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (frame_start)    state_d = ST_ADDR;
                else if (frame_end) state_d = ST_REPORT;
                else if (addr_done) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (frame_start)    state_d = ST_ADDR;
                else if (frame_end) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                state_d = frame_start ? ST_ADDR : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= 1'b0;
            acc_q <= 1'b0;
            grp_q <= 1'b0;
        end else begin
            dec_q <= capture;
            acc_q <= capture && v_ok;
            grp_q <= capture && v_grp;
        end
    end

    assign dec_valid   = dec_q;
    assign accept      = acc_q;
    assign match_group = grp_q;

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       keep_bits,
    input logic             frame_start,
    input logic             frame_end,
    input logic [LEN_W-1:0] frame_len,
    input logic             crc_err,
    input logic             align_err,
    input logic             dec_valid,
    input logic             accept,
    input logic             match_group
);

    p_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(frame_len) >= LEN_W'(MIN_LEN)) || $past(keep_bits[1]));

    p_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !($past(crc_err) || $past(align_err)) || $past(keep_bits[0]));

    p_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_group |-> accept);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> dec_valid);

    p_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(frame_end) && !$past(frame_start));

endmodule

bind rx_addr_filter rx_addr_filter_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .keep_bits  (rx_policy[1:0]),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .frame_len  (frame_len),
    .crc_err    (crc_err),
    .align_err  (align_err),
    .dec_valid  (dec_valid),
    .accept     (accept),
    .match_group(match_group)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

    localparam int AB = 6;
    localparam int HB = 6;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    rx_policy;
    logic [47:0]   station_addr;
    logic [63:0]   hash_table;
    logic          frame_start, dest_valid, frame_end, crc_err, align_err;
    logic [7:0]    dest_byte;
    logic [LW-1:0] frame_len;
    logic          dec_valid, accept, match_group;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rx_addr_filter #(.ADDR_BYTES(AB), .HASH_BITS(HB), .LEN_W(LW), .MIN_LEN(64)) uut (
        .clk(clk), .rst_n(rst_n), .rx_policy(rx_policy), .station_addr(station_addr),
        .hash_table(hash_table), .frame_start(frame_start), .dest_valid(dest_valid),
        .dest_byte(dest_byte), .frame_end(frame_end), .frame_len(frame_len),
        .crc_err(crc_err), .align_err(align_err), .dec_valid(dec_valid),
        .accept(accept), .match_group(match_group)
    );

    function automatic logic [5:0] hidx(input logic [47:0] d);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ d[8*k+i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c[31:26];
    endfunction

    // Returns {accept, match_group}
    function automatic logic [1:0] expect_v(input logic [47:0] d, input int nb,
                                            input int len, input logic ce, input logic ae);
        logic aok, grp;
        if (nb < 6) return 2'b00;
        if (d == 48'hFFFF_FFFF_FFFF) begin
            aok = rx_policy[2]; grp = 1'b1;
        end else if (d[0]) begin
            aok = rx_policy[3] && hash_table[hidx(d)]; grp = 1'b1;
        end else begin
            aok = rx_policy[4] || (d == station_addr); grp = 1'b0;
        end
        if (len < 64 && !rx_policy[1]) aok = 1'b0;
        if ((ce || ae) && !rx_policy[0]) aok = 1'b0;
        return {aok, aok && grp};
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send(input string req, input logic [47:0] d, input int nb,
                        input int len, input logic ce, input logic ae, input bit gaps);
        logic [1:0] exp;
        exp = expect_v(d, nb, len, ce, ae);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < nb; k++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                dest_valid = 1'b0;
                @(negedge clk);
            end
            dest_valid = 1'b1;
            dest_byte  = d[8*k +: 8];
            @(negedge clk);
        end
        dest_valid = 1'b0;
        frame_end  = 1'b1;
        frame_len  = LW'(len);
        crc_err    = ce;
        align_err  = ae;
        @(negedge clk);
        frame_end  = 1'b0;
        crc_err    = 1'b0;
        align_err  = 1'b0;
        check({req, " R8 strobe"}, {1'b0, dec_valid}, 2'b01);
        check(req, {accept, match_group}, exp);
        @(negedge clk);
        check("R8 pulse ends", {dec_valid, accept}, 2'b00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [47:0] d;
        logic [47:0] mc;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_policy = '0; frame_start = 0; dest_valid = 0; dest_byte = 0;
        frame_end = 0; frame_len = 0; crc_err = 0; align_err = 0;
        station_addr = 48'h5544_3322_1100; hash_table = '0;
        repeat (3) @(negedge clk);
        check("R8 reset outputs", {accept, match_group}, 2'b00);
        check("R8 reset strobe", {1'b0, dec_valid}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {dec_valid, accept}, 2'b00);

        // R1 exact unicast and near miss
        rx_policy = 5'b00000;
        send("R1 exact", station_addr, 6, 100, 0, 0, 0);
        send("R1 last byte off", station_addr ^ 48'h0100_0000_0000, 6, 100, 0, 0, 0);
        // R2 promiscuous
        rx_policy = 5'b10000;
        send("R2 promisc other", 48'h0A0B_0C0D_0E10, 6, 100, 0, 0, 0);
        // R3 broadcast
        rx_policy = 5'b10000;
        send("R3 bcast off", 48'hFFFF_FFFF_FFFF, 6, 100, 0, 0, 0);
        rx_policy = 5'b00100;
        send("R3 bcast on R7", 48'hFFFF_FFFF_FFFF, 6, 100, 0, 0, 0);
        // R4 multicast hash
        mc = 48'h0100_005E_0001 | 48'h1;
        hash_table = 64'd1 << hidx(mc);
        rx_policy = 5'b01000;
        send("R4 hash hit", mc, 6, 100, 0, 0, 0);
        hash_table = ~(64'd1 << hidx(mc));
        send("R4 hash miss", mc, 6, 100, 0, 0, 0);
        hash_table = '1;
        rx_policy = 5'b10100;
        send("R4 mcast disabled", mc, 6, 100, 0, 0, 0);
        // R5 runt boundary
        rx_policy = 5'b00000;
        send("R5 len 63", station_addr, 6, 63, 0, 0, 0);
        send("R5 len 64", station_addr, 6, 64, 0, 0, 0);
        rx_policy = 5'b00010;
        send("R5 keep short", station_addr, 6, 20, 0, 0, 0);
        // R6 errors
        rx_policy = 5'b00000;
        send("R6 crc err", station_addr, 6, 100, 1, 0, 0);
        send("R6 align err", station_addr, 6, 100, 0, 1, 0);
        rx_policy = 5'b00001;
        send("R6 keep bad", station_addr, 6, 100, 1, 1, 0);
        // R9 incomplete, stray end, restart
        rx_policy = 5'b10111;
        send("R9 short address", station_addr, 4, 100, 0, 0, 0);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        @(negedge clk);
        check("R9 stray end", {dec_valid, accept}, 2'b00);
        rx_policy = 5'b00000;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            dest_valid = 1'b1; dest_byte = 8'hEE; @(negedge clk);
        end
        dest_valid = 1'b0;
        send("R9 restart", station_addr, 6, 100, 0, 0, 0);

        // Random frames
        for (int n = 0; n < 400; n++) begin
            int sel, len, nb;
            rx_policy    = 5'($urandom);
            station_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
            hash_table   = {$urandom, $urandom};
            sel = $urandom % 6;
            nb  = 6;
            case (sel)
                0: d = station_addr;
                1: d = station_addr ^ (48'h1 << (1 + ($urandom % 47)));
                2: d = 48'hFFFF_FFFF_FFFF;
                3: d = {$urandom, $urandom} | 48'h1;
                4: d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
                default: begin d = station_addr; nb = $urandom % 6; end
            endcase
            case ($urandom % 3)
                0: len = 63;
                1: len = 64;
                default: len = 20 + ($urandom % 1500);
            endcase
            send("R1-random mix R2 R3 R4 R5 R6 R7", d, nb, len,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule